// File: doc/BRIEF.md
# Selectable Flow-Through / Pipelined SRAM Read Path

This block is the output side of a synchronous SRAM with a 32-bit word. It carries array read data to the data pins and decides, cycle by cycle, whether the output drivers are on. The memory array and the address logic sit outside it.

A per-cycle command tag tells the block what the SRAM was asked to do on each clock: read, write or deselect. A strap input picks one of two read behaviours, and the block captures it only while reset is held. In flow-through mode the word from the array passes straight to the pins. In pipelined mode the word first goes through a rising-edge output register, which adds one clock.

Deselect commands go through the same tag pipeline as reads. The drivers therefore switch off at the point where a read issued on that clock would have shown its data. In pipelined mode this is one clock later than a single-stage deselect would switch them off. The active-low output enable acts asynchronously on top of that timing. A write switches all lanes off for its whole cycle.

Top module: `srp_read_path`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every lane enable is 0. Reset clears the output register to zero.
- R2: The mode strap is captured only on clock edges where reset is high: 1 selects pipelined and 0 selects flow-through. A change of the strap while out of reset has no effect on timing.
- R3: Flow-through mode: a read sampled at edge k turns the drivers on during the cycle after edge k. In every cycle of this mode, the data output equals the array data input of that same cycle.
- R4: Pipelined mode: a read sampled at edge k has its array word, taken during the cycle after k, registered at edge k+1. That word is shown and driven during the cycle after edge k+1.
- R5: Back-to-back reads present one new word on every clock in both modes. This gives first-access timing of 2-1-1-1 clocks in flow-through mode and 3-1-1-1 clocks in pipelined mode.
- R6: A deselect follows the same pipeline depth as a read. In pipelined mode, the drivers stay on for one more cycle after a deselect that follows a read, and go off in the cycle after the edge that comes after the deselect's own edge.
- R7: A write sampled at edge k holds every lane off during the cycle after edge k. In pipelined mode this also applies when a read is due to be presented in that cycle.
- R8: A high output enable turns all lanes off in the same cycle, without waiting for a clock. Such a "dummy" read still moves through the pipeline and still loads the output register.
- R9: All lane enables carry the same value in every cycle: a read drives every byte lane.
- R10: The command code is 2 bits: 00 deselect, 01 read, 10 write. Code 11 behaves as a deselect.
- R11: In pipelined mode the output register keeps its last read word through every cycle whose first stage is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; mode strap is captured while high |
| pipe_mode_i | input | 1 | Mode strap: 1 pipelined, 0 flow-through |
| cmd_i | input | 2 | Command tag for this clock (00 deselect, 01 read, 10 write, 11 deselect) |
| rd_data_i | input | DATA_W | Array word for the command in the first stage |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| dout_o | output | DATA_W | Data toward the pins |
| drv_en_o | output | DATA_W/LANE_W | Per-byte-lane driver enable |

## Verification
On every cycle the assertions check the following: the drivers are quiet after reset; a high output enable and a write both gate the drivers off; the lane enables agree with each other; the captured mode stays fixed outside reset; and reads and deselects reach the pins at the latency set by the mode, with the pipelined word equal to the array word of one cycle earlier. The bench's scenarios are needed for the rest. They show that a strap toggled mid-run changes nothing, that the register keeps its word across write, deselect and code-11 cycles, that a dummy read under a high enable still reloads the register, and that a 4-beat burst produces one word per clock in each mode after re-reset.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL     = 2'b00,
    CMD_READ      = 2'b01,
    CMD_WRITE     = 2'b10,
    CMD_DESEL_ALT = 2'b11
  } cmd_e;

  localparam int TAG_W = 2;
endpackage

// File: rtl/srp_cmd_stage.sv
// Shift register of command tags; stage 0 is the array-access cycle.
module srp_cmd_stage #(
  parameter int DEPTH = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [srp_pkg::TAG_W-1:0]       cmd_i,
  output logic [DEPTH-1:0][srp_pkg::TAG_W-1:0] tag_o
);
  logic [DEPTH-1:0][srp_pkg::TAG_W-1:0] tag_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) tag_q[g] <= srp_pkg::CMD_DESEL;
          else     tag_q[g] <= cmd_i;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) tag_q[g] <= srp_pkg::CMD_DESEL;
          else     tag_q[g] <= tag_q[g-1];
        end
      end
    end
  endgenerate

  assign tag_o = tag_q;
endmodule

// File: rtl/srp_out_reg.sv
// Output data register: loads only when the first stage holds a read.
module srp_out_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/srp_drv_ctrl.sv
// Per-lane driver enable: present data, no write blocking, output enable low.
module srp_drv_ctrl #(
  parameter int LANES = 4
) (
  input  logic             present_i,
  input  logic             block_i,
  input  logic             oe_n_i,
  output logic [LANES-1:0] en_o
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign en_o[g] = present_i & ~block_i & ~oe_n_i;
    end
  endgenerate
endmodule

// File: rtl/srp_read_path.sv
module srp_read_path #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pipe_mode_i,
  input  logic [1:0]                 cmd_i,
  input  logic [DATA_W-1:0]          rd_data_i,
  input  logic                       oe_n_i,
  output logic [DATA_W-1:0]          dout_o,
  output logic [DATA_W/LANE_W-1:0]   drv_en_o
);
  import srp_pkg::*;

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 2;

  logic                         mode_pipe_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tags;
  logic [TAG_W-1:0]             s1_tag;
  logic [TAG_W-1:0]             s2_tag;
  logic [DATA_W-1:0]            data_q;
  logic                         present_rd;
  logic                         write_hold;

  // Strap capture: only while reset is asserted.
  always_ff @(posedge clk) begin
    if (rst) mode_pipe_q <= pipe_mode_i;
  end

  srp_cmd_stage #(.DEPTH(DEPTH)) u_stage (
    .clk   (clk),
    .rst   (rst),
    .cmd_i (cmd_i),
    .tag_o (tags)
  );

  assign s1_tag = tags[0];
  assign s2_tag = tags[1];

  srp_out_reg #(.WIDTH(DATA_W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .load_i (s1_tag == CMD_READ),
    .d_i    (rd_data_i),
    .q_o    (data_q)
  );

  assign present_rd = mode_pipe_q ? (s2_tag == CMD_READ) : (s1_tag == CMD_READ);
  assign write_hold = (s1_tag == CMD_WRITE);

  srp_drv_ctrl #(.LANES(LANES)) u_drv (
    .present_i (present_rd),
    .block_i   (write_hold),
    .oe_n_i    (oe_n_i),
    .en_o      (drv_en_o)
  );

  assign dout_o = mode_pipe_q ? data_q : rd_data_i;
endmodule

// File: rtl/srp_read_path_chk.sv
module srp_read_path_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_pipe_q,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] dout_o,
  input logic [LANES-1:0]  drv_en_o
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> drv_en_o == '0); // R1

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_pipe_q)); // R2

  AST_FT_READ_ON: assert property (@(posedge clk) disable iff (rst)
    (!mode_pipe_q && !$past(rst) && $past(cmd_i) == 2'b01 && !oe_n_i) |-> drv_en_o == '1); // R3

  AST_PIPE_READ_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_pipe_q && !$past(rst) && !$past(rst, 2) && $past(cmd_i, 2) == 2'b01
     && $past(cmd_i) != 2'b10 && !oe_n_i) |-> drv_en_o == '1); // R4

  AST_PIPE_DATA: assert property (@(posedge clk) disable iff (rst)
    (mode_pipe_q && !$past(rst) && !$past(rst, 2) && $past(cmd_i, 2) == 2'b01)
    |-> dout_o == $past(rd_data_i)); // R4

  AST_PIPE_DESEL_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_pipe_q && !$past(rst) && !$past(rst, 2)
     && ($past(cmd_i, 2) == 2'b00 || $past(cmd_i, 2) == 2'b11)) |-> drv_en_o == '0); // R6

  AST_WRITE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_i) == 2'b10) |-> drv_en_o == '0); // R7

  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> drv_en_o == '0); // R8

  AST_LANES_SAME: assert property (@(posedge clk) disable iff (rst)
    (drv_en_o == '0) || (drv_en_o == '1)); // R9
endmodule

bind srp_read_path srp_read_path_chk #(.DATA_W(DATA_W), .LANES(DATA_W / LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_pipe_q (mode_pipe_q),
  .cmd_i       (cmd_i),
  .rd_data_i   (rd_data_i),
  .oe_n_i      (oe_n_i),
  .dout_o      (dout_o),
  .drv_en_o    (drv_en_o)
);

// File: tb/tb_srp_read_path.sv
`timescale 1ns/100ps
module tb_srp_read_path;
  localparam int DATA_W = 32;
  localparam int LANES  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pipe_mode_i = 1'b1;
  logic [1:0]        cmd_i = 2'b00;
  logic [DATA_W-1:0] rd_data_i = '0;
  logic              oe_n_i = 1'b0;
  logic [DATA_W-1:0] dout_o;
  logic [LANES-1:0]  drv_en_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Reference model state
  logic [1:0]        stg[$];
  logic              mq = 1'b1;
  logic [DATA_W-1:0] dq = '0;
  logic              last_load = 1'b0;
  string             phase = "";

  always #2 clk = ~clk;

  srp_read_path #(.DATA_W(DATA_W), .LANE_W(8)) dut (
    .clk(clk), .rst(rst), .pipe_mode_i(pipe_mode_i), .cmd_i(cmd_i),
    .rd_data_i(rd_data_i), .oe_n_i(oe_n_i), .dout_o(dout_o), .drv_en_o(drv_en_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input logic ok, input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic       exp_en;
    logic [1:0] rel;
    string      tag;
    logic [DATA_W-1:0] exp_d;
    rel    = mq ? stg[1] : stg[0];
    exp_en = (rel == 2'b01) && (stg[0] != 2'b10) && !oe_n_i;
    if (oe_n_i)               tag = "R8";
    else if (stg[0] == 2'b10) tag = "R7";
    else if (rel == 2'b01)    tag = mq ? "R4" : "R3";
    else if (rel == 2'b11)    tag = "R10";
    else                      tag = "R6";
    check((drv_en_o == '0) || (drv_en_o == '1), "R9", DATA_W'(drv_en_o), '0);
    check(drv_en_o == {LANES{exp_en}}, tag, DATA_W'(drv_en_o), DATA_W'({LANES{exp_en}}));
    exp_d = mq ? dq : rd_data_i;
    check(dout_o == exp_d, mq ? (last_load ? "R4" : "R11") : "R3", dout_o, exp_d);
  endtask

  task automatic step(input logic [1:0] c, input logic [DATA_W-1:0] d, input logic oe);
    @(posedge clk);
    cycles++;
    if (rst) begin
      mq = pipe_mode_i;
      stg = '{2'b00, 2'b00};
      dq = '0;
      last_load = 1'b0;
    end else begin
      last_load = (stg[0] == 2'b01);
      if (last_load) dq = rd_data_i;
      stg.push_front(cmd_i);
      void'(stg.pop_back());
    end
    #1;
    cmd_i = c; rd_data_i = d; oe_n_i = oe;
    #1;
    compare();
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    pipe_mode_i = mode;
    for (int i = 0; i < 3; i++) step(2'b00, $urandom, 1'b0);
    rst = 1'b0;
    step(2'b00, $urandom, 1'b0);
    // R1: first cycle after release, drivers off and register cleared
    check(drv_en_o == '0, "R1", DATA_W'(drv_en_o), '0);
    if (mode) check(dout_o == '0, "R1", dout_o, '0);
  endtask

  task automatic directed();
    phase = "(R5 burst)";
    for (int i = 0; i < 4; i++) step(2'b01, $urandom, 1'b0);
    phase = "(R6 deselect)";
    step(2'b00, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    phase = "(R7 write after read)";
    step(2'b01, $urandom, 1'b0);
    step(2'b10, $urandom, 1'b0);
    step(2'b01, $urandom, 1'b0);
    step(2'b10, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    phase = "(R8 dummy read)";
    step(2'b01, 32'hA5A5_0001, 1'b1);
    step(2'b00, $urandom, 1'b1);
    step(2'b00, $urandom, 1'b0);
    step(2'b01, $urandom, 1'b0);
    step(2'b01, $urandom, 1'b1);
    step(2'b00, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    phase = "(R10 code 11)";
    step(2'b01, $urandom, 1'b0);
    step(2'b11, $urandom, 1'b0);
    step(2'b11, $urandom, 1'b0);
    step(2'b01, $urandom, 1'b0);
    step(2'b00, $urandom, 1'b0);
    phase = "(R11 hold)";
    for (int i = 0; i < 4; i++) step(2'($urandom_range(0, 3) & 2'b10), $urandom, 1'b0);
  endtask

  task automatic random_run(input int n, input logic toggle_strap);
    phase = toggle_strap ? "(R2 strap ignored)" : "(random)";
    for (int i = 0; i < n; i++) begin
      if (toggle_strap && (i % 17 == 0)) pipe_mode_i = ~pipe_mode_i;
      step(2'($urandom_range(0, 3)), $urandom, ($urandom_range(0, 7) == 0));
    end
  endtask

  initial begin
    stg = '{2'b00, 2'b00};
    do_reset(1'b1);
    directed();
    random_run(400, 1'b1);
    do_reset(1'b0);
    directed();
    random_run(400, 1'b1);
    do_reset(1'b1);
    random_run(200, 1'b0);
    report();
  end

  initial begin
    #(4 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end
endmodule